// File: doc/BRIEF.md
# Time Base and Decrementer Unit

This block keeps a processor's notion of elapsed time. It holds two 64-bit up-counters, a main time base and an alternate time base, each with its own independent value. It also holds a 32-bit down-counting decrementer that raises an interrupt request. All three advance only on clock cycles where the tick-enable input is high. Software reaches them through a small register port that moves 32-bit words.

A run input gates the two time bases. While run is low, both hold their values. When run returns high, both resume from the values they held. The decrementer ignores the run input. It counts on every tick. When it expires it reloads to all ones and raises its interrupt. A software write can also raise the interrupt, if it moves bit 31 of the decrementer from clear to set. The interrupt stays raised until the acknowledge input clears it.

A legacy real-time-clock view of the main time base's lower word shows only the bits selected by the mask 0x3FFFFF80.

Top module: `tbdec_unit`

## Requirements
- R1: After reset, both time bases read zero, the decrementer reads 0xFFFFFFFF and `dec_irq` is low.
- R2: A write to address 0 replaces bits 31:0 of the main time base and keeps bits 63:32. A write to address 1 replaces bits 63:32 and keeps bits 31:0. Reads of addresses 0 and 1 return those same halves.
- R3: Addresses 2 and 3 access the low and high halves of the alternate time base. They behave the same way as addresses 0 and 1, and they do not touch the main time base.
- R4: On a cycle with `tick_en` and `tb_run` both high and no write to it, each time base increments by exactly one.
- R5: While `tb_run` is low, both time bases hold their values. Counting resumes from the held values when `tb_run` goes high again. The decrementer keeps counting on ticks while the time bases are held.
- R6: Address 4 is the decrementer. On a tick with no write to it, the decrementer decrements by one. A tick taken while it reads zero reloads it to 0xFFFFFFFF and raises `dec_irq`.
- R7: A write to address 4 with bit 31 set, while the current decrementer value has bit 31 clear, raises `dec_irq` on the next cycle. Any other write to address 4 leaves `dec_irq` as it was.
- R8: `dec_irq` stays high until a cycle with `dec_ack` high clears it. When a raise event and `dec_ack` fall in the same cycle, the raise wins.
- R9: When a write and a tick fall in the same cycle, the written value is stored and the tick is lost for the written register.
- R10: Address 5 is the legacy clock view. Reads return the lower word of the main time base ANDed with 0x3FFFFF80. Writes store the write data ANDed with that mask into bits 31:0 and keep bits 63:32.
- R11: Addresses 6 and 7 read zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Count enable for all counters |
| tb_run | input | 1 | Time base run; low holds both time bases |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select (0..7) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| dec_ack | input | 1 | Clears the decrementer interrupt |
| dec_irq | output | 1 | Decrementer interrupt pending |

## Verification
The assertions expect at most one register write per cycle, with known address and data whenever `reg_wr` is high. They also expect `tick_en`, `tb_run` and `dec_ack` to be settled before the sampling edge. The stimulus changes every input only at the falling clock edge and issues a single write strobe at a time. Random write data is biased toward small decrementer values, so expiry happens often. Unmapped addresses appear in the random mix.

// File: rtl/tbdec_pkg.sv
package tbdec_pkg;
    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        SEL_TB_LO  = 3'd0,
        SEL_TB_HI  = 3'd1,
        SEL_ALT_LO = 3'd2,
        SEL_ALT_HI = 3'd3,
        SEL_DEC    = 3'd4,
        SEL_RTC_LO = 3'd5
    } sel_e;

    localparam logic [WORD_W-1:0] RTC_MASK = 32'h3FFF_FF80;
    localparam logic [WORD_W-1:0] DEC_INIT = '1;
endpackage

// File: rtl/tbdec_timebase.sv
module tbdec_timebase #(
    parameter int HALF_W = 32,
    localparam int FULL_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [HALF_W-1:0] wdata,
    output logic [FULL_W-1:0] value
);
    typedef struct packed {
        logic [FULL_W-1:0] cnt;
    } tb_state_t;

    tb_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_lo || wr_hi) begin
            if (wr_lo) st_d.cnt[HALF_W-1:0]      = wdata;
            if (wr_hi) st_d.cnt[FULL_W-1:HALF_W] = wdata;
        end else if (adv) begin
            st_d.cnt = st_q.cnt + FULL_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign value = st_q.cnt;

    AST_LO_WR_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !wr_hi) |=> value[FULL_W-1:HALF_W] == $past(value[FULL_W-1:HALF_W])); // R2
    AST_HI_WR_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !wr_lo) |=> value[HALF_W-1:0] == $past(value[HALF_W-1:0])); // R2
    AST_TB_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr_lo && !wr_hi) |=> value == $past(value) + FULL_W'(1)); // R4
    AST_TB_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !wr_lo && !wr_hi) |=> $stable(value)); // R5
    AST_WR_OVER_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && wr_lo) |=> value[HALF_W-1:0] == $past(wdata)); // R9
endmodule

// File: rtl/tbdec_decr.sv
module tbdec_decr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         ack,
    output logic [W-1:0] value,
    output logic         irq
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic         pend;
    } dec_state_t;

    dec_state_t st_d, st_q;
    logic       raise;

    always_comb begin
        st_d  = st_q;
        raise = 1'b0;
        if (wr) begin
            raise    = wdata[W-1] && !st_q.cnt[W-1];
            st_d.cnt = wdata;
        end else if (tick) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = '1;
                raise    = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - W'(1);
            end
        end
        if (raise)    st_d.pend = 1'b1;
        else if (ack) st_d.pend = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= '1;
            st_q.pend <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign value = st_q.cnt;
    assign irq   = st_q.pend;

    AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr && value != '0) |=> value == $past(value) - W'(1)); // R6
    AST_DEC_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr && value == '0) |=> (value == '1) && irq); // R6
    AST_DEC_SIGN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && wdata[W-1] && !value[W-1]) |=> irq); // R7
    AST_IRQ_CLEARED_BY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(ack)); // R8
endmodule

// File: rtl/tbdec_unit.sv
module tbdec_unit
    import tbdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              tb_run,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              dec_ack,
    output logic              dec_irq
);
    localparam int NUM_TB = 2;
    localparam int FULL_W = 2 * WORD_W;

    sel_e              sel;
    logic [NUM_TB-1:0] wr_lo, wr_hi;
    logic [WORD_W-1:0] tb_wdata [NUM_TB];
    logic [FULL_W-1:0] tb_val   [NUM_TB];
    logic [WORD_W-1:0] dec_val;
    logic              dec_wr;

    assign sel = sel_e'(reg_addr);

    always_comb begin
        wr_lo       = '0;
        wr_hi       = '0;
        tb_wdata[0] = reg_wdata;
        tb_wdata[1] = reg_wdata;
        if (reg_wr) begin
            case (sel)
                SEL_TB_LO:  wr_lo[0] = 1'b1;
                SEL_TB_HI:  wr_hi[0] = 1'b1;
                SEL_ALT_LO: wr_lo[1] = 1'b1;
                SEL_ALT_HI: wr_hi[1] = 1'b1;
                SEL_RTC_LO: begin
                    wr_lo[0]    = 1'b1;
                    tb_wdata[0] = reg_wdata & RTC_MASK;
                end
                default: ;
            endcase
        end
    end

    assign dec_wr = reg_wr && (sel == SEL_DEC);

    for (genvar g = 0; g < NUM_TB; g++) begin : g_tb
        tbdec_timebase #(.HALF_W(WORD_W)) tb_i (
            .clk   (clk),
            .rst_n (rst_n),
            .adv   (tick_en && tb_run),
            .wr_lo (wr_lo[g]),
            .wr_hi (wr_hi[g]),
            .wdata (tb_wdata[g]),
            .value (tb_val[g])
        );
    end

    tbdec_decr #(.W(WORD_W)) dec_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_en),
        .wr    (dec_wr),
        .wdata (reg_wdata),
        .ack   (dec_ack),
        .value (dec_val),
        .irq   (dec_irq)
    );

    always_comb begin
        case (sel)
            SEL_TB_LO:  reg_rdata = tb_val[0][WORD_W-1:0];
            SEL_TB_HI:  reg_rdata = tb_val[0][FULL_W-1:WORD_W];
            SEL_ALT_LO: reg_rdata = tb_val[1][WORD_W-1:0];
            SEL_ALT_HI: reg_rdata = tb_val[1][FULL_W-1:WORD_W];
            SEL_DEC:    reg_rdata = dec_val;
            SEL_RTC_LO: reg_rdata = tb_val[0][WORD_W-1:0] & RTC_MASK;
            default:    reg_rdata = '0;
        endcase
    end

    AST_RTC_WR_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && sel == SEL_RTC_LO) |=> tb_val[0][WORD_W-1:0] == ($past(reg_wdata) & RTC_MASK)); // R10
    AST_UNMAPPED_WR_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr > 3'd5 && !tick_en) |=> ($stable(tb_val[0]) && $stable(tb_val[1]) && $stable(dec_val))); // R11
    AST_ALT_UNTOUCHED_BY_MAIN_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (sel == SEL_TB_LO || sel == SEL_TB_HI) && !(tick_en && tb_run)) |=> $stable(tb_val[1])); // R3
endmodule

// File: tb/tbdec_unit_tb_top.sv
module tbdec_unit_tb_top;
    localparam logic [31:0] MASK = 32'h3FFF_FF80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0, tb_run = 1'b0, reg_wr = 1'b0, dec_ack = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dec_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [63:0] m_tb, m_alt;
    logic [31:0] m_dec;
    logic        m_irq;

    always #5 clk = ~clk;

    tbdec_unit dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .tb_run(tb_run),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .dec_ack(dec_ack), .dec_irq(dec_irq)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(int a);
        case (a)
            0: return m_tb[31:0];
            1: return m_tb[63:32];
            2: return m_alt[31:0];
            3: return m_alt[63:32];
            4: return m_dec;
            5: return m_tb[31:0] & MASK;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string req_of(int a);
        case (a)
            0, 1: return "R2 main time base";
            2, 3: return "R3 alternate time base";
            4: return "R6 decrementer";
            5: return "R10 legacy clock view";
            default: return "R11 unmapped read";
        endcase
    endfunction

    // Spec model, applied for the inputs held across one rising edge
    function automatic void model_step();
        logic raise = 1'b0;
        logic tb_w  = reg_wr && (reg_addr == 3'd0 || reg_addr == 3'd1 || reg_addr == 3'd5);
        logic alt_w = reg_wr && (reg_addr == 3'd2 || reg_addr == 3'd3);
        if (!tb_w && tick_en && tb_run) m_tb = m_tb + 64'd1;
        if (!alt_w && tick_en && tb_run) m_alt = m_alt + 64'd1;
        if (reg_wr) begin
            case (reg_addr)
                3'd0: m_tb[31:0]   = reg_wdata;
                3'd1: m_tb[63:32]  = reg_wdata;
                3'd2: m_alt[31:0]  = reg_wdata;
                3'd3: m_alt[63:32] = reg_wdata;
                3'd5: m_tb[31:0]   = reg_wdata & MASK;
                default: ;
            endcase
        end
        if (reg_wr && reg_addr == 3'd4) begin
            raise = reg_wdata[31] && !m_dec[31];
            m_dec = reg_wdata;
        end else if (tick_en) begin
            if (m_dec == 32'h0) begin
                m_dec = 32'hFFFF_FFFF;
                raise = 1'b1;
            end else begin
                m_dec = m_dec - 32'd1;
            end
        end
        if (raise) m_irq = 1'b1;
        else if (dec_ack) m_irq = 1'b0;
    endfunction

    task automatic check_all();
        reg_wr = 1'b0; tick_en = 1'b0; dec_ack = 1'b0;
        for (int a = 0; a < 8; a++) begin
            reg_addr = 3'(a);
            #0.5;
            chk(req_of(a), reg_rdata, exp_read(a));
        end
        chk("R8 interrupt pending", {31'd0, dec_irq}, {31'd0, m_irq});
    endtask

    task automatic cyc(logic t, logic r, logic w, logic [2:0] a, logic [31:0] d, logic k);
        tick_en = t; tb_run = r; reg_wr = w; reg_addr = a; reg_wdata = d; dec_ack = k;
        @(posedge clk);
        model_step();
        @(negedge clk);
        check_all();
    endtask

    task automatic rd(logic [2:0] a, string req, logic [31:0] exp);
        reg_addr = a;
        #0.5;
        chk(req, reg_rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0042);
        m_tb = '0; m_alt = '0; m_dec = 32'hFFFF_FFFF; m_irq = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(3'd0, "R1 tb lo", 32'h0);
        rd(3'd1, "R1 tb hi", 32'h0);
        rd(3'd3, "R1 alt hi", 32'h0);
        rd(3'd4, "R1 dec", 32'hFFFF_FFFF);
        chk("R1 irq", {31'd0, dec_irq}, 32'h0);

        // R2 half writes
        cyc(0, 1, 1, 3'd1, 32'hAAAA_5555, 0);
        cyc(0, 1, 1, 3'd0, 32'hFFFF_FFFE, 0);
        rd(3'd1, "R2 hi kept", 32'hAAAA_5555);
        // R4 count with carry into upper half
        cyc(1, 1, 0, 3'd0, 0, 0);
        cyc(1, 1, 0, 3'd0, 0, 0);
        rd(3'd1, "R4 carry", 32'hAAAA_5556);
        rd(3'd0, "R4 wrap", 32'h0);
        // R3 alternate independent
        cyc(0, 1, 1, 3'd2, 32'h1234_5678, 0);
        rd(3'd2, "R3 alt lo", 32'h1234_5678);
        rd(3'd0, "R3 main untouched", 32'h0);
        // R5 freeze: time bases hold, decrementer counts
        cyc(0, 0, 1, 3'd4, 32'h0000_0100, 0);
        repeat (4) cyc(1, 0, 0, 3'd0, 0, 0);
        rd(3'd2, "R5 alt held", 32'h1234_5678);
        rd(3'd4, "R5 dec counts", 32'h0000_00FC);
        cyc(1, 1, 0, 3'd0, 0, 0);
        rd(3'd2, "R5 resume", 32'h1234_5679);
        // R9 write beats tick
        cyc(1, 1, 1, 3'd0, 32'h0000_0005, 0);
        rd(3'd0, "R9 write wins", 32'h0000_0005);
        // R6 expiry
        cyc(0, 1, 1, 3'd4, 32'h0000_0002, 0);
        repeat (2) cyc(1, 0, 0, 3'd0, 0, 0);
        rd(3'd4, "R6 at zero", 32'h0);
        chk("R6 no irq yet", {31'd0, dec_irq}, 32'h0);
        cyc(1, 0, 0, 3'd0, 0, 0);
        rd(3'd4, "R6 reload", 32'hFFFF_FFFF);
        chk("R6 irq raised", {31'd0, dec_irq}, 32'h1);
        // R8 held until ack
        repeat (3) cyc(0, 0, 0, 3'd0, 0, 0);
        chk("R8 irq held", {31'd0, dec_irq}, 32'h1);
        cyc(0, 0, 0, 3'd0, 0, 1);
        chk("R8 ack clears", {31'd0, dec_irq}, 32'h0);
        // R7 sign-changing write
        cyc(0, 0, 1, 3'd4, 32'h0000_0010, 0);
        chk("R7 positive write no irq", {31'd0, dec_irq}, 32'h0);
        cyc(0, 0, 1, 3'd4, 32'h8000_0000, 0);
        chk("R7 sign write raises", {31'd0, dec_irq}, 32'h1);
        cyc(0, 0, 0, 3'd0, 0, 1);
        cyc(0, 0, 1, 3'd4, 32'h9000_0000, 0);
        chk("R7 already negative no irq", {31'd0, dec_irq}, 32'h0);
        // R8 raise beats ack
        cyc(0, 0, 1, 3'd4, 32'h0000_0010, 0);
        cyc(0, 0, 1, 3'd4, 32'h8000_0001, 1);
        chk("R8 raise over ack", {31'd0, dec_irq}, 32'h1);
        // R10 legacy view
        cyc(0, 1, 1, 3'd5, 32'hFFFF_FFFF, 0);
        rd(3'd0, "R10 masked store", MASK);
        rd(3'd5, "R10 masked read", MASK);
        // R11 unmapped write
        cyc(0, 1, 1, 3'd7, 32'hDEAD_BEEF, 0);
        rd(3'd0, "R11 no effect", MASK);
        rd(3'd7, "R11 reads zero", 32'h0);

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [2:0]  a = 3'($urandom_range(0, 7));
            logic [31:0] d = $urandom();
            if (a == 3'd4 && $urandom_range(0, 1) == 0) d = $urandom_range(0, 20);
            cyc($urandom_range(0, 9) < 7, $urandom_range(0, 9) < 8,
                $urandom_range(0, 99) < 15, a, d, $urandom_range(0, 9) == 0);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule